// File: doc/BRIEF.md
# Sequential 8-bit Multiply-Divide Unit

This unit performs either an unsigned 8×8 multiply or an unsigned 8÷8 divide on an operand pair that plays the role of an accumulator (A) and a companion B register. A one-cycle start pulse, qualified by an operation select, captures both operands. The unit then works for a fixed four clock cycles and raises a one-cycle done pulse. At that moment the results land in the two result registers, together with the carry and overflow flags.

For a multiply, the result pair holds the 16-bit product, with the low byte in A and the high byte in B. Overflow reports whether the product needs more than eight bits. For a divide, A receives the quotient and B receives the remainder. A zero divisor is reported through the same overflow flag. Carry is cleared by both operations. Internally, each cycle retires two bits: two radix-4 multiply steps or two restoring divide iterations.

Top module: `mdu8_top`

## Requirements
- R1: A multiply of operands a and b yields a_o = (a·b) mod 256 and b_o = (a·b) / 256.
- R2: After a multiply, ov_o is 1 exactly when a·b is greater than 255.
- R3: Every completed operation leaves cy_o at 0.
- R4: A divide with b ≠ 0 yields a_o = a / b (integer quotient), b_o = a mod b, and ov_o = 0.
- R5: A divide with b = 0 sets ov_o to 1. It leaves a_o equal to the dividend a and b_o equal to 00h.
- R6: done_o is high for exactly one cycle, after the fourth rising edge following the edge that accepted start_i. It is never high while busy_o is high.
- R7: busy_o is high for the four cycles that follow an accepted start. A start_i seen while busy_o is high is ignored: it neither changes the running operation nor its result.
- R8: After reset, a_o, b_o, cy_o, ov_o, busy_o and done_o are all 0. The result outputs and flags change only when done_o rises.
- R9: A start_i sampled in the done_o cycle is accepted, so operations may run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled on the rising edge when the unit is idle |
| div_sel_i | input | 1 | Operation select: 0 = multiply, 1 = divide |
| a_i | input | 8 | First operand: multiplicand or dividend |
| b_i | input | 8 | Second operand: multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse; results are valid from this cycle on |
| a_o | output | 8 | Result A: low product byte or quotient |
| b_o | output | 8 | Result B: high product byte or remainder |
| cy_o | output | 1 | Carry flag |
| ov_o | output | 1 | Overflow flag: product above 255, or zero divisor |

## Verification
The result registers change only on the done cycle. Any corruption of the shared partial register pair therefore stays hidden until done_o rises, four cycles after the start, and then shows up as a wrong byte in a_o or b_o. A fault in the step counter shows up sooner: done_o or busy_o moves off the fixed four-cycle schedule on the very cycle the count diverges. A lost divide-by-zero marker appears at completion, as a cleared ov_o or a disturbed a_o. The bench therefore compares every output against a timing model on every cycle, so both kinds of fault are caught on the first cycle they become visible.

// File: rtl/mdu8_pkg.sv
package mdu8_pkg;
  // Operand width and bits retired per cycle
  parameter int unsigned DATA_W    = 8;
  parameter int unsigned RADIX_W   = 2;
  localparam int unsigned N_STEPS  = DATA_W / RADIX_W;
  localparam int unsigned CNT_W    = (N_STEPS > 1) ? $clog2(N_STEPS) : 1;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } op_e;
endpackage

// File: rtl/mdu8_seq.sv
module mdu8_seq
  import mdu8_pkg::*;
#(
  parameter int unsigned STEPS = N_STEPS,
  parameter int unsigned CW    = CNT_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  localparam logic [CW-1:0] LAST_CNT = CW'(STEPS - 1);

  always_comb begin
    load_o = start_i && !busy_q;
    step_o = busy_q;
    last_o = busy_q && (cnt_q == LAST_CNT);
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load_o) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
      if (last_o) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_CNT_ZERO_AT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (cnt_q == '0) && busy_q); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> done_q && !busy_q); // R6
endmodule

// File: rtl/mdu8_mul_stage.sv
module mdu8_mul_stage
  import mdu8_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  parameter int unsigned K = RADIX_W
) (
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] mcand_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  // hi holds the running upper partial product; lo's low K bits are the next
  // multiplier digit, and the vacated top of lo collects retired product bits.
  logic [W+K-1:0] digit_prod;
  logic [W+K-1:0] sum;

  always_comb begin
    digit_prod = {{W{1'b0}}, lo_i[K-1:0]} * {{K{1'b0}}, mcand_i};
    sum        = {{K{1'b0}}, hi_i} + digit_prod;
    hi_o       = sum[W+K-1:K];
    lo_o       = {sum[K-1:0], lo_i[W-1:K]};
  end
endmodule

// File: rtl/mdu8_div_stage.sv
module mdu8_div_stage
  import mdu8_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  parameter int unsigned K = RADIX_W
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvsr_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  // Chain of K restoring iterations; quo shifts the dividend out at the top
  // and the quotient bits in at the bottom.
  logic [W-1:0] rem_c [K+1];
  logic [W-1:0] quo_c [K+1];

  assign rem_c[0] = rem_i;
  assign quo_c[0] = quo_i;

  for (genvar g = 0; g < K; g++) begin : g_iter
    logic [W:0] trial;
    logic [W:0] diff;
    logic       fits;
    always_comb begin
      trial = {rem_c[g], quo_c[g][W-1]};
      diff  = trial - {1'b0, dvsr_i};
      fits  = (trial >= {1'b0, dvsr_i});
    end
    assign rem_c[g+1] = fits ? diff[W-1:0] : trial[W-1:0];
    assign quo_c[g+1] = {quo_c[g][W-2:0], fits};
  end

  assign rem_o = rem_c[K];
  assign quo_o = quo_c[K];
endmodule

// File: rtl/mdu8_top.sv
module mdu8_top
  import mdu8_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  parameter int unsigned K = RADIX_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         div_sel_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         cy_o,
  output logic         ov_o
);
  localparam int unsigned STEPS = W / K;
  localparam int unsigned CW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic load, step, last;

  // Shared datapath registers
  op_e          op_q, op_d;
  logic         dz_q, dz_d;
  logic [W-1:0] hi_q, hi_d, lo_q, lo_d, opd_q, opd_d;
  logic         dp_en;
  // Result registers
  logic [W-1:0] ra_q, ra_d, rb_q, rb_d;
  logic         cy_q, cy_d, ov_q, ov_d;
  logic         res_en;

  logic [W-1:0] mul_hi, mul_lo, div_rem, div_quo;

  mdu8_seq #(.STEPS(STEPS), .CW(CW)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .load_o(load), .step_o(step), .last_o(last),
    .busy_o(busy_o), .done_o(done_o)
  );

  mdu8_mul_stage #(.W(W), .K(K)) mul_i (
    .hi_i(hi_q), .lo_i(lo_q), .mcand_i(opd_q),
    .hi_o(mul_hi), .lo_o(mul_lo)
  );

  mdu8_div_stage #(.W(W), .K(K)) div_i (
    .rem_i(hi_q), .quo_i(lo_q), .dvsr_i(opd_q),
    .rem_o(div_rem), .quo_o(div_quo)
  );

  always_comb begin
    op_d  = op_q;
    dz_d  = dz_q;
    hi_d  = hi_q;
    lo_d  = lo_q;
    opd_d = opd_q;
    dp_en = 1'b0;
    if (load) begin
      dp_en = 1'b1;
      hi_d  = '0;
      if (div_sel_i) begin
        op_d  = OP_DIV;
        dz_d  = (b_i == '0);
        lo_d  = a_i;
        opd_d = b_i;
      end else begin
        op_d  = OP_MUL;
        dz_d  = 1'b0;
        lo_d  = b_i;
        opd_d = a_i;
      end
    end else if (step && !dz_q) begin
      dp_en = 1'b1;
      if (op_q == OP_DIV) begin
        hi_d = div_rem;
        lo_d = div_quo;
      end else begin
        hi_d = mul_hi;
        lo_d = mul_lo;
      end
    end
  end

  always_comb begin
    res_en = last;
    ra_d   = ra_q;
    rb_d   = rb_q;
    cy_d   = 1'b0;
    ov_d   = ov_q;
    if (dz_q) begin
      ra_d = lo_q;
      rb_d = opd_q;
      ov_d = 1'b1;
    end else if (op_q == OP_DIV) begin
      ra_d = div_quo;
      rb_d = div_rem;
      ov_d = 1'b0;
    end else begin
      ra_d = mul_lo;
      rb_d = mul_hi;
      ov_d = (mul_hi != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_MUL;
      dz_q  <= 1'b0;
      hi_q  <= '0;
      lo_q  <= '0;
      opd_q <= '0;
    end else if (dp_en) begin
      op_q  <= op_d;
      dz_q  <= dz_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      opd_q <= opd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q <= '0;
      rb_q <= '0;
      cy_q <= 1'b0;
      ov_q <= 1'b0;
    end else if (res_en) begin
      ra_q <= ra_d;
      rb_q <= rb_d;
      cy_q <= cy_d;
      ov_q <= ov_d;
    end
  end

  assign a_o  = ra_q;
  assign b_o  = rb_q;
  assign cy_o = cy_q;
  assign ov_o = ov_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !done_o); // R6
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R7
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> $stable(opd_q) && $stable(op_q)); // R7
  AST_DIVZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && dz_q) |-> ov_o && (b_o == '0)); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(a_o) && $stable(b_o) && $stable(ov_o)); // R8
endmodule

// File: tb/mdu8_top_tb_top.sv
module mdu8_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       div_sel_i = 1'b0;
  logic [7:0] a_i = '0;
  logic [7:0] b_i = '0;
  logic       busy_o, done_o, cy_o, ov_o;
  logic [7:0] a_o, b_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #10 clk = ~clk; // 50 MHz

  mdu8_top dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .div_sel_i(div_sel_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
    .a_o(a_o), .b_o(b_o), .cy_o(cy_o), .ov_o(ov_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // Behavioural reference model (kind: 0 none, 1 mul, 2 div, 3 div by zero)
  bit m_busy, m_done, m_ov;
  int m_cnt, m_a, m_b, m_kind;
  int p_div, p_a, p_b;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_ov = 0; m_cnt = 0;
      m_a = 0; m_b = 0; m_kind = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 4) begin
          m_busy = 0;
          m_done = 1;
          if (p_div == 0) begin
            m_a = (p_a * p_b) % 256; m_b = (p_a * p_b) / 256;
            m_ov = (p_a * p_b) > 255; m_kind = 1;
          end else if (p_b == 0) begin
            m_a = p_a; m_b = 0; m_ov = 1; m_kind = 3;
          end else begin
            m_a = p_a / p_b; m_b = p_a % p_b; m_ov = 0; m_kind = 2;
          end
        end
      end else if (start_i) begin
        m_busy = 1; m_cnt = 0;
        p_div = int'(div_sel_i); p_a = int'(a_i); p_b = int'(b_i);
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      string rt;
      rt = (m_kind == 1) ? "R1" : (m_kind == 3) ? "R5" : (m_kind == 2) ? "R4" : "R8";
      check(rt, "a_o", int'(a_o), m_a);
      check(rt, "b_o", int'(b_o), m_b);
      check((m_kind == 1) ? "R2" : rt, "ov_o", int'(ov_o), int'(m_ov));
      check("R3", "cy_o", int'(cy_o), 0);
      check("R6", "done_o", int'(done_o), int'(m_done));
      check("R7", "busy_o", int'(busy_o), int'(m_busy));
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
      $finish;
    end
  end

  // Drive start in the current negedge cycle, release it one cycle later, wait for done.
  task automatic run_op(input bit dv, input int a, input int b);
    div_sel_i = dv; a_i = 8'(a); b_i = 8'(b); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset values
    check("R8", "reset a_o", int'(a_o), 0);
    check("R8", "reset ov_o", int'(ov_o), 0);
    check("R8", "reset busy_o", int'(busy_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(0, 8'h50, 8'hA0); // R1 R2
    check("R1", "mul 50x A0 a_o", int'(a_o), 8'h00);
    check("R1", "mul 50x A0 b_o", int'(b_o), 8'h32);
    check("R2", "mul 50x A0 ov_o", int'(ov_o), 1);
    check("R3", "mul cy_o", int'(cy_o), 0);

    run_op(1, 251, 18); // R4, back to back R9
    check("R4", "div 251/18 a_o", int'(a_o), 13);
    check("R4", "div 251/18 b_o", int'(b_o), 17);
    check("R4", "div 251/18 ov_o", int'(ov_o), 0);

    run_op(1, 8'h9C, 0); // R5
    check("R5", "div by zero a_o", int'(a_o), 8'h9C);
    check("R5", "div by zero b_o", int'(b_o), 0);
    check("R5", "div by zero ov_o", int'(ov_o), 1);

    run_op(0, 8'h0F, 8'h11); // R2 boundary: 255 exactly
    check("R2", "mul 0F x 11 ov_o", int'(ov_o), 0);
    run_op(0, 8'h10, 8'h10); // R2 boundary: 256
    check("R2", "mul 10 x 10 ov_o", int'(ov_o), 1);
    run_op(0, 8'hFF, 8'hFF); // R1 largest
    check("R1", "mul FF x FF b_o", int'(b_o), 8'hFE);
    run_op(1, 8'h05, 8'h09); // R4 small dividend
    check("R4", "div 5/9 b_o", int'(b_o), 5);
    run_op(1, 8'hFF, 8'h01); // R4 divide by one
    check("R4", "div FF/1 a_o", int'(a_o), 8'hFF);

    // R7: a start while busy is ignored
    div_sel_i = 1'b0; a_i = 8'h07; b_i = 8'h06; start_i = 1'b1;
    @(negedge clk);
    div_sel_i = 1'b1; a_i = 8'h40; b_i = 8'h00;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    check("R7", "ignored start a_o", int'(a_o), 42);
    check("R7", "ignored start ov_o", int'(ov_o), 0);

    // R8: outputs hold across idle cycles
    repeat (5) @(negedge clk);
    check("R8", "hold a_o", int'(a_o), 42);

    for (int i = 0; i < 300; i++) begin
      int gap;
      run_op(bit'($urandom_range(0, 1)), int'($urandom_range(0, 255)),
             ($urandom_range(0, 15) == 0) ? 0 : int'($urandom_range(0, 255)));
      gap = int'($urandom_range(0, 3));
      for (int j = 0; j < gap; j++) @(negedge clk);
    end

    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule